// File: doc/BRIEF.md
# Configurable Digital Glitch Filter Bank

This block conditions a bank of digital input pins. Each pin has its own filter that holds back a new input level until that level has been seen unchanged for more filter ticks than a shared programmable length. Shorter disturbances never reach the output. A disabled filter drives a constant zero and forgets its history. All filters share one length setting and one tick source.

The tick source is either every cycle of the block clock (fast mode) or an externally supplied slow strobe, such as a divided low-power tick. Both are handled as a clock enable inside a single clock domain. A small word-addressed register port writes and reads back the per-pin enable mask, the source select and the length. The length and the source should only be changed while all filters are disabled. Pins that have no filter hardware are marked by a parameter mask. Their enable bit is fixed at zero.

Top module: `glitch_filter_bank`

## Requirements
- R1: After a synchronous reset every `pin_out` bit is 0, and the enable, source and length registers all read back as 0.
- R2: The enable register is at address 0x00, with bit i controlling pin i. Bits whose `SUPPORT_MASK` bit is 0 read as 0, ignore writes, and their `pin_out` stays 0.
- R3: When a pin's enable bit is 0, its `pin_out` is 0 from the cycle after the write that cleared it. Re-enabling restarts the filter with no memory of earlier samples.
- R4: The source register is at address 0x04, with bit 0 as the select: 0 gives a filter tick every cycle, 1 gives a tick only in cycles where `slow_tick` is 1. Bits 31:1 read as 0.
- R5: The length register is at address 0x08 and holds a value L in bits 4:0. Bits 31:5 read as 0.
- R6: An input level held for L filter ticks or fewer never appears on `pin_out`.
- R7: An input level held for L+1 consecutive filter ticks appears on `pin_out` at the clock edge of the (L+1)-th tick. The output always equals the input level that was sampled. This includes L = 31, where 32 ticks are needed.
- R8: With L = 0, a level seen on a single filter tick passes at that tick's edge.
- R9: An enabled output whose enable did not change can only change on an edge where a filter tick was present.
- R10: Reads from any other address return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | Slow filter tick strobe, used when the source select is 1 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` (combinational) |
| pin_in | input | NUM_PINS | Raw pin levels |
| pin_out | output | NUM_PINS | Filtered pin levels |

## Verification
The assertions check four things on every cycle: outputs stay low for disabled and unsupported pins, outputs clear after reset, an enabled output changes only on a tick edge, and a changed output always carries the input level sampled at that edge. They cannot count how many ticks a level has been stable. For that reason, the exact pass and suppress boundaries at L and L+1 ticks are covered only by the bench's scenarios and its cycle-accurate model. The same applies to the L = 0 and L = 31 extremes, to slow-tick counting, to register readback and to the behaviour of unmapped addresses.

// File: rtl/gf_pkg.sv
// Package: shared constants and types of the glitch filter bank.
// Assumes byte addresses on a word-aligned register port.
package gf_pkg;

    // Register byte offsets
    localparam int OFS_ENABLE = 'h00;
    localparam int OFS_SOURCE = 'h04;
    localparam int OFS_LENGTH = 'h08;

    // Filter tick source
    typedef enum logic {
        SRC_FAST = 1'b0,
        SRC_SLOW = 1'b1
    } gf_src_e;

endpackage

// File: rtl/gf_regs.sv
// Module: gf_regs
// Holds the enable mask, the tick source select and the filter length.
// Reads are combinational. Writes take effect at the next clock edge.
// Assumes NUM_PINS <= DATA_W and LEN_W < DATA_W.
module gf_regs #(
    parameter int NUM_PINS = 32,
    parameter int LEN_W    = 5,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter logic [NUM_PINS-1:0] SUPPORT_MASK = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [NUM_PINS-1:0] en_o,
    output gf_pkg::gf_src_e     src_o,
    output logic [LEN_W-1:0]    len_o
);
    import gf_pkg::*;

    localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFS_ENABLE);
    localparam logic [ADDR_W-1:0] A_SRC = ADDR_W'(OFS_SOURCE);
    localparam logic [ADDR_W-1:0] A_LEN = ADDR_W'(OFS_LENGTH);

    logic [NUM_PINS-1:0] en_q;
    gf_src_e             src_q;
    logic [LEN_W-1:0]    len_q;

    // Register update: masked enable write, select and length writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            src_q <= SRC_FAST;
            len_q <= '0;
        end else if (we) begin
            case (addr)
                A_EN:    en_q  <= wdata[NUM_PINS-1:0] & SUPPORT_MASK;
                A_SRC:   src_q <= gf_src_e'(wdata[0]);
                A_LEN:   len_q <= wdata[LEN_W-1:0];
                default: ;
            endcase
        end
    end

    // Read multiplexer: reserved bits and unmapped addresses return zero
    always_comb begin
        rdata = '0;
        case (addr)
            A_EN:    rdata[NUM_PINS-1:0] = en_q;
            A_SRC:   rdata[0]            = src_q;
            A_LEN:   rdata[LEN_W-1:0]    = len_q;
            default: rdata = '0;
        endcase
    end

    assign en_o  = en_q;
    assign src_o = src_q;
    assign len_o = len_q;

endmodule

// File: rtl/gf_tick.sv
// Module: gf_tick
// Produces the shared filter tick enable from the selected source.
// Fast mode ticks every cycle. Slow mode follows an external strobe,
// which is assumed to be already synchronous to clk.
module gf_tick (
    input  gf_pkg::gf_src_e src,
    input  logic            slow_tick,
    output logic            tick
);
    import gf_pkg::*;

    // Source selection
    always_comb begin
        case (src)
            SRC_SLOW: tick = slow_tick;
            default:  tick = 1'b1;
        endcase
    end

endmodule

// File: rtl/gf_cell.sv
// Module: gf_cell
// One pin filter. On each tick it samples din and counts consecutive
// ticks with an unchanged sample (saturating). When that count exceeds
// len, the sampled level is copied to the output. While en is low the
// state is cleared and dout is forced low.
// Assumes din is already synchronous to clk.
module gf_cell #(
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [LEN_W-1:0] len,
    input  logic             din,
    output logic             dout
);
    localparam int               CNT_W   = LEN_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic             samp_q;
    logic             out_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             pass;

    // Next run length and pass decision for the current sample
    always_comb begin
        if (din != samp_q)         cnt_nxt = CNT_ONE;
        else if (cnt_q == CNT_MAX) cnt_nxt = cnt_q;
        else                       cnt_nxt = cnt_q + CNT_ONE;
        pass = (cnt_nxt > {1'b0, len});
    end

    // Filter state: cleared on reset or disable, advanced on tick
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            samp_q <= 1'b0;
            cnt_q  <= '0;
            out_q  <= 1'b0;
        end else if (tick) begin
            samp_q <= din;
            cnt_q  <= cnt_nxt;
            if (pass) out_q <= din;
        end
    end

    assign dout = en & out_q;

endmodule

// File: rtl/glitch_filter_bank.sv
// Module: glitch_filter_bank (top)
// A bank of NUM_PINS glitch filters with one register port and one
// shared tick. Pins whose SUPPORT_MASK bit is 0 have no filter cell
// and a constant zero output. Assumes NUM_PINS <= DATA_W and that
// length and source change only while all filters are disabled.
module glitch_filter_bank #(
    parameter int NUM_PINS = 32,
    parameter int LEN_W    = 5,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter logic [NUM_PINS-1:0] SUPPORT_MASK = 32'h0FFF_FFFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                slow_tick,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out
);
    import gf_pkg::*;

    logic [NUM_PINS-1:0] en_q;
    gf_src_e             src_q;
    logic [LEN_W-1:0]    len_q;
    logic                filt_tick;

    gf_regs #(
        .NUM_PINS     (NUM_PINS),
        .LEN_W        (LEN_W),
        .DATA_W       (DATA_W),
        .ADDR_W       (ADDR_W),
        .SUPPORT_MASK (SUPPORT_MASK)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .en_o  (en_q),
        .src_o (src_q),
        .len_o (len_q)
    );

    gf_tick u_tick (
        .src       (src_q),
        .slow_tick (slow_tick),
        .tick      (filt_tick)
    );

    // One filter per supported pin; unsupported pins tie low
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        if (SUPPORT_MASK[i]) begin : g_cell
            gf_cell #(.LEN_W(LEN_W)) u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (en_q[i]),
                .tick  (filt_tick),
                .len   (len_q),
                .din   (pin_in[i]),
                .dout  (pin_out[i])
            );
        end else begin : g_none
            assign pin_out[i] = 1'b0;
        end
    end

endmodule

// File: rtl/gf_checker.sv
// Module: gf_checker
// Property checks for glitch_filter_bank, attached by bind.
module gf_checker #(
    parameter int NUM_PINS = 32,
    parameter logic [NUM_PINS-1:0] SUPPORT_MASK = '1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] pin_in,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] en,
    input logic                tick
);
    logic rst_prev = 1'b1;

    // Output clear one edge after a reset edge
    always_ff @(posedge clk) begin
        rst_prev <= rst_n;
        if (!rst_prev) begin
            AST_RESET_CLEAR: assert (pin_out == '0); // R1
        end
    end

    AST_UNSUPPORTED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~SUPPORT_MASK) == '0); // R2

    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~en) == '0); // R3

    AST_CHANGE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (((pin_out ^ $past(pin_out)) & en & $past(en)) != '0) |-> $past(tick)); // R9

    AST_CHANGE_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out ^ $past(pin_out)) & en & $past(en) & (pin_out ^ $past(pin_in))) == '0); // R7

endmodule

bind glitch_filter_bank gf_checker #(
    .NUM_PINS     (NUM_PINS),
    .SUPPORT_MASK (SUPPORT_MASK)
) u_gf_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_in  (pin_in),
    .pin_out (pin_out),
    .en      (en_q),
    .tick    (filt_tick)
);

// File: tb/glitch_filter_bank_bench.sv
module glitch_filter_bank_bench;
    localparam int NP = 32;
    localparam int LW = 5;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam logic [NP-1:0] MASK = 32'h0FFF_FFFF;
    localparam logic [AW-1:0] A_EN = 8'h00, A_SRC = 8'h04, A_LEN = 8'h08, A_BAD = 8'h10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slow_tick = 1'b0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;

    glitch_filter_bank #(
        .NUM_PINS(NP), .LEN_W(LW), .DATA_W(DW), .ADDR_W(AW), .SUPPORT_MASK(MASK)
    ) u_glitch_filter_bank (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_in(pin_in), .pin_out(pin_out)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Bench reference state
    logic [NP-1:0] en_exp = '0;
    logic          sel_exp = 1'b0;
    logic [LW-1:0] len_exp = '0;
    logic [NP-1:0] m_samp = '0;
    logic [NP-1:0] m_out = '0;
    int            m_cnt [NP];
    logic [NP-1:0] cur_in = '0;
    logic          cur_tick = 1'b0;
    string         cur_tag = "R1";

    function automatic logic [NP-1:0] expected_out();
        return en_exp & m_out;
    endfunction

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock edge of the reference filters, using pre-edge settings
    task automatic model_edge();
        logic t;
        t = sel_exp ? cur_tick : 1'b1;
        for (int i = 0; i < NP; i++) begin
            if (!en_exp[i]) begin
                m_samp[i] = 1'b0; m_cnt[i] = 0; m_out[i] = 1'b0;
            end else if (t) begin
                if (cur_in[i] != m_samp[i]) begin
                    m_samp[i] = cur_in[i]; m_cnt[i] = 1;
                end else if (m_cnt[i] < 63) begin
                    m_cnt[i]++;
                end
                if (m_cnt[i] > int'(len_exp)) m_out[i] = m_samp[i];
            end
        end
    endtask

    task automatic edge_and_check(logic we, logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        pin_in = cur_in; slow_tick = cur_tick;
        reg_we = we; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1;
        model_edge();
        if (we) begin
            case (a)
                A_EN:  en_exp  = d[NP-1:0] & MASK;
                A_SRC: sel_exp = d[0];
                A_LEN: len_exp = d[LW-1:0];
                default: ;
            endcase
        end
        reg_we = 1'b0;
        chk(cur_tag, DW'(pin_out), DW'(expected_out()));
    endtask

    task automatic cycle();
        edge_and_check(1'b0, A_BAD, '0);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
        edge_and_check(1'b1, a, d);
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [DW-1:0] v;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NP; i++) m_cnt[i] = 0;

        // R1: reset state
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cur_tag = "R1";
        chk("R1 pin_out", DW'(pin_out), '0);
        rd(A_EN, v);  chk("R1 enable", v, '0);
        rd(A_SRC, v); chk("R1 source", v, '0);
        rd(A_LEN, v); chk("R1 length", v, '0);

        // R5 and R4: reserved bits read zero
        cur_tag = "R5";
        wr(A_LEN, 32'hFFFF_FFE3);
        rd(A_LEN, v); chk("R5 length field", v, 32'h3);
        cur_tag = "R4";
        wr(A_SRC, 32'hFFFF_FFFE);
        rd(A_SRC, v); chk("R4 source reserved", v, 32'h0);

        // R10: unmapped address
        cur_tag = "R10";
        wr(A_BAD, 32'hFFFF_FFFF);
        rd(A_BAD, v); chk("R10 unmapped read", v, '0);
        rd(A_EN, v);  chk("R10 enable untouched", v, '0);
        rd(A_LEN, v); chk("R10 length untouched", v, 32'h3);

        // R2: masked enable bits
        cur_tag = "R2";
        wr(A_EN, 32'hFFFF_FFFF);
        rd(A_EN, v); chk("R2 enable readback", v, DW'(MASK));

        // R6 / R7 with L=3 on pin 0; pin 31 unsupported and held high
        cur_tag = "R6";
        cur_in = 32'h8000_0001;
        for (int k = 0; k < 3; k++) begin
            cycle(); chk("R6 short pulse held back", DW'(pin_out[0]), 0);
        end
        cur_in = 32'h8000_0000;
        for (int k = 0; k < 4; k++) cycle();
        chk("R6 pulse of L ticks removed", DW'(pin_out[0]), 0);
        chk("R2 unsupported pin low", DW'(pin_out[31]), 0);
        cur_tag = "R7";
        cur_in = 32'h8000_0001;
        for (int k = 0; k < 3; k++) cycle();
        chk("R7 before L+1 ticks", DW'(pin_out[0]), 0);
        cycle();
        chk("R7 at L+1 ticks", DW'(pin_out[0]), 1);

        // R3: disable forces low, re-enable restarts
        cur_tag = "R3";
        wr(A_EN, 32'h0);
        chk("R3 disabled output", DW'(pin_out), '0);
        wr(A_EN, 32'hFFFF_FFFF);
        for (int k = 0; k < 3; k++) cycle();
        chk("R3 restart needs full count", DW'(pin_out[0]), 0);
        cycle();
        chk("R3 passes after restart", DW'(pin_out[0]), 1);

        // R8: L=0 single-tick pass
        cur_tag = "R8";
        cur_in = '0;
        wr(A_EN, 0); wr(A_LEN, 0); wr(A_EN, 32'hFFFF_FFFF);
        cycle(); cycle();
        cur_in = 32'h1; cycle();
        chk("R8 one tick passes", DW'(pin_out[0]), 1);
        cur_in = 32'h0; cycle();
        chk("R8 one tick return", DW'(pin_out[0]), 0);

        // R7: L=31 boundary on pin 1
        cur_tag = "R7";
        wr(A_EN, 0); wr(A_LEN, 31); wr(A_EN, 32'hFFFF_FFFF);
        cur_in = 32'h2;
        for (int k = 0; k < 31; k++) cycle();
        chk("R7 L=31 held back at 31", DW'(pin_out[1]), 0);
        cycle();
        chk("R7 L=31 passes at 32", DW'(pin_out[1]), 1);

        // R4 / R9: slow ticks, L=1 on pin 2
        cur_tag = "R4";
        cur_in = '0;
        wr(A_EN, 0); wr(A_LEN, 1); wr(A_SRC, 1); wr(A_EN, 32'hFFFF_FFFF);
        cur_in = 32'h4; cur_tick = 1'b0;
        for (int k = 0; k < 10; k++) cycle();
        chk("R4 no tick no change", DW'(pin_out[2]), 0);
        cur_tag = "R9";
        cur_tick = 1'b1; cycle(); cur_tick = 1'b0;
        for (int k = 0; k < 3; k++) cycle();
        chk("R9 one slow tick held", DW'(pin_out[2]), 0);
        cur_tick = 1'b1; cycle(); cur_tick = 1'b0;
        chk("R9 second slow tick passes", DW'(pin_out[2]), 1);

        // Random rounds against the reference model
        cur_tag = "R6/R7 random";
        for (int r = 0; r < 8; r++) begin
            logic [LW-1:0] lv;
            case (r)
                0: lv = 0; 1: lv = 1; 2: lv = 2; 3: lv = 3;
                4: lv = 5; 5: lv = 8; 6: lv = 0; default: lv = 31;
            endcase
            cur_in = '0; cur_tick = 1'b0;
            wr(A_EN, 0); wr(A_LEN, DW'(lv)); wr(A_SRC, DW'(r % 2)); wr(A_EN, 32'hFFFF_FFFF);
            for (int c = 0; c < 250; c++) begin
                cur_in = cur_in ^ ($urandom & $urandom & $urandom);
                cur_tick = (($urandom % 3) == 0);
                cycle();
            end
        end

        finish_run();
    end
endmodule